// File: doc/BRIEF.md
# Dual Bidirectional Port with Direction Control

This block provides two 8-bit peripheral ports, A and B, behind a small register-select bus. Each port has an output latch and a direction mask. A mask bit set to 1 makes the matching pin drive the latched value. A mask bit cleared to 0 leaves the pin as an input, held high by a modelled pull-up. The tri-state pin drivers appear as separate enable and value vectors. The external world appears as a per-bit drive-enable and drive-value pair, and the block resolves the pin level from both.

A read of a port returns the resolved pin level of each bit. For a driven bit, that level is the latched value. For an input bit, it is the external level, or 1 when nothing drives the pin. The top bit of port B can also carry an active-low interrupt: while the override is enabled and the interrupt request is active, that pin is driven low.

Top module: `dual_port_gpio`

## Requirements
- R1: After reset, both direction masks and both output latches are 0. All pin enables are 0, and an undriven port reads as all ones.
- R2: Register select encoding: 0 is port A output latch, 1 is port A direction, 2 is port B output latch, 3 is port B direction. A write lands on the rising clock edge where `cs` and `we` are both high.
- R3: For each bit, the pin enable equals the direction bit. While the pin is enabled, the pin value equals the output latch bit. While the pin is not enabled, the pin value is 0.
- R4: An input bit reads the external value when the external drive-enable bit is 1. It reads 1 when that drive-enable bit is 0.
- R5: A port data read returns the latch bit for output bits and the pin level for input bits, mixed bit by bit in one read.
- R6: A read never changes an output latch. A write with `cs` low or `we` low changes no register.
- R7: Reading select 1 or 3 returns the current direction mask of that port.
- R8: When `irq_en` and `irq_req` are both 1, port B bit 7 has its enable forced to 1 and its value forced to 0, and that bit reads as 0.
- R9: When `irq_en` is 0, `irq_req` has no effect on port B pins or reads.
- R10: `rdata` is valid in the same cycle as `cs` and `re`, with no clock edge needed. It is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Block select |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rsel | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq_en | input | 1 | Enables the interrupt override on port B bit 7 |
| irq_req | input | 1 | Interrupt request from the timer |
| pa_ext_en | input | 8 | External drive enable per port A pin |
| pa_ext_val | input | 8 | External drive value per port A pin |
| pa_oe | output | 8 | Port A pin driver enable |
| pa_out | output | 8 | Port A pin driver value |
| pb_ext_en | input | 8 | External drive enable per port B pin |
| pb_ext_val | input | 8 | External drive value per port B pin |
| pb_oe | output | 8 | Port B pin driver enable |
| pb_out | output | 8 | Port B pin driver value |

## Verification
The bench uses the default parameters: 8-bit ports, with the override placed on bit 7 of port B. At this width, mixed direction masks such as 0xF0 and 0x5A put driven bits and input bits side by side in one read. The override bit can be tested both while it is configured as an input and while it is configured as an output. Because the width is small, every pin can be checked after each step, so any stray enable or value bit shows up.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_A_DATA = 2'd0,
    SEL_A_DIR  = 2'd1,
    SEL_B_DATA = 2'd2,
    SEL_B_DIR  = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int W       = 8,
  parameter bit HAS_OVR = 1'b0,
  parameter int OVR_BIT = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic         ovr_act,
  input  logic [W-1:0] ext_en,
  input  logic [W-1:0] ext_val,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] lvl,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] odr_q;
  logic [W-1:0] ovr_mask;
  logic [W-1:0] eff_oe;
  logic [W-1:0] eff_val;

  function automatic logic [W-1:0] resolve(input logic [W-1:0] oe, input logic [W-1:0] drv,
                                           input logic [W-1:0] xen, input logic [W-1:0] xval);
    return (oe & drv) | (~oe & xen & xval) | (~oe & ~xen);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odr_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_data) odr_q <= wdata;
      if (wr_dir)  dir_q <= wdata;
    end
  end

  generate
    if (HAS_OVR) begin : g_ovr
      always_comb begin
        ovr_mask = '0;
        ovr_mask[OVR_BIT] = ovr_act;
      end
    end else begin : g_no_ovr
      assign ovr_mask = '0;
    end
  endgenerate

  assign eff_oe  = dir_q | ovr_mask;
  assign eff_val = odr_q & ~ovr_mask;
  assign pin_oe  = eff_oe;
  assign pin_out = eff_oe & eff_val;
  assign lvl     = resolve(eff_oe, eff_val, ext_en, ext_val);

  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(odr_q));
  a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> odr_q == $past(wdata));
  a_r5_out_bits_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl ^ odr_q) & dir_q & ~ovr_mask) == '0);
  a_r4_free_inputs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (~lvl & ~pin_oe & ~ext_en) == '0);
  generate
    if (HAS_OVR) begin : g_ovr_chk
      a_r8_ovr_low: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_act |-> (pin_oe[OVR_BIT] && !pin_out[OVR_BIT] && !lvl[OVR_BIT]));
    end
  endgenerate
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int W = 8
) (
  input  logic         rd_en,
  input  logic [1:0]   sel,
  input  logic [W-1:0] a_lvl,
  input  logic [W-1:0] a_dir,
  input  logic [W-1:0] b_lvl,
  input  logic [W-1:0] b_dir,
  output logic [W-1:0] rdata
);
  import gpio_pkg::*;
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (gpio_sel_e'(sel))
        SEL_A_DATA: rdata = a_lvl;
        SEL_A_DIR:  rdata = a_dir;
        SEL_B_DATA: rdata = b_lvl;
        SEL_B_DIR:  rdata = b_dir;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_port_gpio.sv
module dual_port_gpio #(
  parameter int W       = 8,
  parameter int IRQ_BIT = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         we,
  input  logic         re,
  input  logic [1:0]   rsel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         irq_en,
  input  logic         irq_req,
  input  logic [W-1:0] pa_ext_en,
  input  logic [W-1:0] pa_ext_val,
  output logic [W-1:0] pa_oe,
  output logic [W-1:0] pa_out,
  input  logic [W-1:0] pb_ext_en,
  input  logic [W-1:0] pb_ext_val,
  output logic [W-1:0] pb_oe,
  output logic [W-1:0] pb_out
);
  import gpio_pkg::*;

  logic         wr_go;
  logic         rd_go;
  logic         irq_fire;
  logic [W-1:0] a_lvl, a_dir, b_lvl, b_dir;

  assign wr_go    = cs & we;
  assign rd_go    = cs & re;
  assign irq_fire = irq_en & irq_req;

  gpio_port_bank #(.W(W), .HAS_OVR(1'b0), .OVR_BIT(0)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_go && rsel == SEL_A_DATA),
    .wr_dir (wr_go && rsel == SEL_A_DIR),
    .wdata(wdata), .ovr_act(1'b0),
    .ext_en(pa_ext_en), .ext_val(pa_ext_val),
    .pin_oe(pa_oe), .pin_out(pa_out), .lvl(a_lvl), .dir_q(a_dir)
  );

  gpio_port_bank #(.W(W), .HAS_OVR(1'b1), .OVR_BIT(IRQ_BIT)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_go && rsel == SEL_B_DATA),
    .wr_dir (wr_go && rsel == SEL_B_DIR),
    .wdata(wdata), .ovr_act(irq_fire),
    .ext_en(pb_ext_en), .ext_val(pb_ext_val),
    .pin_oe(pb_oe), .pin_out(pb_out), .lvl(b_lvl), .dir_q(b_dir)
  );

  gpio_read_mux #(.W(W)) u_rmux (
    .rd_en(rd_go), .sel(rsel),
    .a_lvl(a_lvl), .a_dir(a_dir), .b_lvl(b_lvl), .b_dir(b_dir),
    .rdata(rdata)
  );

  a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |-> rdata == '0);
  a_r9_no_ovr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> pb_oe == b_dir);
  a_r3_a_enable_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_out & ~pa_oe) == '0);
endmodule

// File: tb/tb_dual_port_gpio.sv
module tb_dual_port_gpio;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic cs = 0, we = 0, re = 0;
  logic [1:0] rsel = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic irq_en = 0, irq_req = 0;
  logic [W-1:0] pa_ext_en = 0, pa_ext_val = 0, pa_oe, pa_out;
  logic [W-1:0] pb_ext_en = 0, pb_ext_val = 0, pb_oe, pb_out;
  int checks = 0, fails = 0;
  logic [W-1:0] m_odr_a = 0, m_dir_a = 0, m_odr_b = 0, m_dir_b = 0;

  always #2.5 clk = ~clk;

  dual_port_gpio dut (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_lvl(input logic [W-1:0] dir, input logic [W-1:0] odr,
                                           input logic [W-1:0] xen, input logic [W-1:0] xv,
                                           input bit ovr);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (ovr && i == W-1) r[i] = 1'b0;
      else if (dir[i]) r[i] = odr[i];
      else if (xen[i]) r[i] = xv[i];
      else r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d, input bit c = 1, input bit w = 1);
    @(negedge clk);
    cs = c; we = w; re = 0; rsel = s; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
    if (c && w) begin
      case (s)
        2'd0: m_odr_a = d;
        2'd1: m_dir_a = d;
        2'd2: m_odr_b = d;
        default: m_dir_b = d;
      endcase
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
    @(negedge clk);
    cs = 1; re = 1; we = 0; rsel = s;
    #1 v = rdata;
    cs = 0; re = 0;
  endtask

  task automatic check_pins(input string tag);
    bit ov;
    logic [W-1:0] eo;
    ov = irq_en && irq_req;
    #1;
    chk({tag, " R3 pa_oe"}, pa_oe, m_dir_a);
    chk({tag, " R3 pa_out"}, pa_out, m_dir_a & m_odr_a);
    eo = m_dir_b; if (ov) eo[W-1] = 1'b1;
    chk({tag, " R3 pb_oe"}, pb_oe, eo);
    eo = m_dir_b & m_odr_b; if (ov) eo[W-1] = 1'b0;
    chk({tag, " R3 pb_out"}, pb_out, eo);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(2'd0, v); chk("R1 port A reads ones", v, 8'hFF);
    rd(2'd1, v); chk("R1 dir A zero", v, 8'h00);
    rd(2'd2, v); chk("R1 port B reads ones", v, 8'hFF);
    rd(2'd3, v); chk("R1 dir B zero", v, 8'h00);
    check_pins("R1");
  endtask

  task automatic t_select_and_drive();
    logic [W-1:0] v;
    wr(2'd1, 8'hF0); wr(2'd0, 8'hA5);
    wr(2'd3, 8'h0F); wr(2'd2, 8'h3C);
    rd(2'd1, v); chk("R7 dir A readback", v, 8'hF0);
    rd(2'd3, v); chk("R7 dir B readback", v, 8'h0F);
    check_pins("R2");
  endtask

  task automatic t_mixed_read();
    logic [W-1:0] v;
    pa_ext_en = 8'h05; pa_ext_val = 8'h04;
    rd(2'd0, v); chk("R5 R4 port A mix", v, exp_lvl(m_dir_a, m_odr_a, pa_ext_en, pa_ext_val, 0));
    wr(2'd1, 8'h5A);
    pa_ext_en = 8'hFF; pa_ext_val = 8'h00;
    rd(2'd0, v); chk("R5 port A mix 5A", v, exp_lvl(m_dir_a, m_odr_a, pa_ext_en, pa_ext_val, 0));
    pb_ext_en = 8'hF0; pb_ext_val = 8'h90;
    rd(2'd2, v); chk("R4 port B mix", v, exp_lvl(m_dir_b, m_odr_b, pb_ext_en, pb_ext_val, 0));
    check_pins("R5");
  endtask

  task automatic t_no_side_effect();
    logic [W-1:0] v;
    for (int i = 0; i < 3; i++) rd(2'd0, v);
    wr(2'd0, 8'h11, 0, 1);
    wr(2'd2, 8'h22, 1, 0);
    wr(2'd1, 8'h00, 0, 1);
    wr(2'd3, 8'hFF, 1, 0);
    check_pins("R6");
    rd(2'd1, v); chk("R6 dir A unchanged", v, m_dir_a);
    rd(2'd3, v); chk("R6 dir B unchanged", v, m_dir_b);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R6 odr A kept through reads", v, 8'hA5);
  endtask

  task automatic t_irq();
    logic [W-1:0] v;
    pb_ext_en = 8'h00;
    irq_en = 0; irq_req = 1;
    rd(2'd2, v); chk("R9 no override when disabled", v, exp_lvl(m_dir_b, m_odr_b, pb_ext_en, pb_ext_val, 0));
    check_pins("R9");
    irq_en = 1;
    rd(2'd2, v); chk("R8 override reads low", v, exp_lvl(m_dir_b, m_odr_b, pb_ext_en, pb_ext_val, 1));
    check_pins("R8");
    wr(2'd3, 8'hFF); wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R8 override beats output bit", v, 8'h7F);
    check_pins("R8 out");
    irq_req = 0;
    rd(2'd2, v); chk("R8 released", v, 8'hFF);
    check_pins("R8 rel");
    irq_en = 0;
  endtask

  task automatic t_idle_rdata();
    @(negedge clk); cs = 1; re = 0; rsel = 2'd0; #1;
    chk("R10 rdata zero without read", rdata, 8'h00);
    cs = 0; re = 1; #1;
    chk("R10 rdata zero without cs", rdata, 8'h00);
    re = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select_and_drive();
    t_mixed_read();
    t_no_side_effect();
    t_irq();
    t_idle_rdata();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule